// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a serial-input digital-to-analog converter. A host drives a serial data line and a shift clock. It also drives two active-low strobes, one for load and one for clear. Each accepted shift-clock rising edge moves one bit into a shift register. The word is sent most significant bit first, and the register always holds the last N bits it received. No bit counting or word framing takes place.

A holding register drives the parallel code that goes to the converter core. That register behaves like a latch. It is open while load is low, and clear overrides it by forcing it to zero. Code zero is zero scale. Code all-ones is full scale, which sits one LSB below the reference.

All four host inputs are asynchronous to the system clock. The block samples them through a synchronizer chain and detects the shift-clock edge in the system clock domain, so no real latch is inferred. The word width is a parameter. It defaults to 12 and may also be set to 10.

Top module: `sdac_input_reg`

## Requirements
- R1: After reset the parallel code is all zeros, and the shift register is all zeros: a load with no shifting presents code 0.
- R2: Each shift-clock rising edge with load and clear both high shifts the register left by one. The serial input enters bit 0. After N edges the first bit sent sits in bit N-1, and only the last N bits are kept.
- R3: While load is low and clear is high, the code follows the shift register contents within SYNC_STAGES+1 system clock cycles.
- R4: While load is low, shift-clock edges leave the shift register unchanged.
- R5: While clear is low, the code is zero regardless of load and shift clock.
- R6: While clear is low, shift-clock edges do not shift, and the shift register keeps its contents.
- R7: If load rises while clear is low, the code stays zero after clear is released.
- R8: If clear rises while load is still low, the code takes the current shift register contents.
- R9: While load and clear are both high, the code keeps its last value, including while new bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all host inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shift_clk | input | 1 | Host shift clock; its rising edges advance the shift register |
| ser_in | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive transfer strobe |
| clear_n | input | 1 | Active-low clear of the holding register |
| dac_code | output | WIDTH | Parallel code to the converter core |

## Verification
Two functions can land in the same sampling cycle: the clear override and the transparent load path. One case has clear returning high while load is still low. The other has load rising while clear is still low. The bench drives each ordering and then holds the strobes steady. It then judges the settled code against a model of the shift register: either the shifted word or zero, depending on which strobe released first. Shift-clock edges are also issued while each strobe is asserted. This shows that the blocked shift leaves the register intact, which the next transparent load reveals.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Action applied to the holding register in one system cycle
  typedef enum logic [1:0] {
    HOLD_KEEP  = 2'd0,
    HOLD_TRACK = 2'd1,
    HOLD_ZERO  = 2'd2
  } hold_op_e;

  // Clear has priority; an open load makes the register follow the shifter
  function automatic hold_op_e hold_op(input logic load_n_s, input logic clear_n_s);
    if (!clear_n_s)     return HOLD_ZERO;
    else if (!load_n_s) return HOLD_TRACK;
    else                return HOLD_KEEP;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned        WIDTH   = 4,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdin_s,
  input  logic             load_n_s,
  input  logic             clear_n_s,
  output logic [WIDTH-1:0] sr_o
);
  logic             sclk_prev_q;
  logic             sclk_rise;
  logic             shift_en;
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  // Shifting is frozen whenever either strobe is asserted
  assign shift_en  = sclk_rise & load_n_s & clear_n_s;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WIDTH-2:0], sdin_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      sr_q        <= sr_d;
    end
  end

  assign sr_o = sr_q;

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(sdin_s));
  // R4 R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_s || !clear_n_s) |=> $stable(sr_q));
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold
  import sdac_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n_s,
  input  logic             clear_n_s,
  input  logic [WIDTH-1:0] sr_i,
  output logic [WIDTH-1:0] code_o
);
  hold_op_e         op;
  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] code_d;

  assign op = hold_op(load_n_s, clear_n_s);

  always_comb begin
    unique case (op)
      HOLD_ZERO:  code_d = '0;
      HOLD_TRACK: code_d = sr_i;
      default:    code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n_s |=> code_q == '0);
  // R3
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && !load_n_s) |=> code_q == $past(sr_i));
  // R9
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n_s && load_n_s) |=> $stable(code_q));
endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg #(
  parameter int unsigned WIDTH       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             ser_in,
  input  logic             load_n,
  input  logic             clear_n,
  output logic [WIDTH-1:0] dac_code
);
  localparam int unsigned NSIG = 4;
  // bit order in the synchronized bundle
  localparam int unsigned B_SCLK = 0;
  localparam int unsigned B_SDIN = 1;
  localparam int unsigned B_LOAD = 2;
  localparam int unsigned B_CLR  = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = NSIG'(4'b1100);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic [NSIG-1:0]  raw;
  logic [NSIG-1:0]  syn;
  logic [WIDTH-1:0] sr;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  always_comb begin
    raw         = '0;
    raw[B_SCLK] = shift_clk;
    raw[B_SDIN] = ser_in;
    raw[B_LOAD] = load_n;
    raw[B_CLR]  = clear_n;
  end

  sdac_sync #(
    .WIDTH   (NSIG),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_VAL)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (raw),
    .sync_o  (syn)
  );

  sdac_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sclk_s    (syn[B_SCLK]),
    .sdin_s    (syn[B_SDIN]),
    .load_n_s  (syn[B_LOAD]),
    .clear_n_s (syn[B_CLR]),
    .sr_o      (sr)
  );

  sdac_hold #(.WIDTH(WIDTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_n_s  (syn[B_LOAD]),
    .clear_n_s (syn[B_CLR]),
    .sr_i      (sr),
    .code_o    (dac_code)
  );
endmodule

// File: tb/sim_sdac_input_reg.sv
module sim_sdac_input_reg;
  localparam int W = 12;
  localparam int SETTLE = 8;

  typedef struct packed {
    logic [15:0] data;
    logic [4:0]  nbits;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0ABC, 5'd12},
    '{16'h0FFF, 5'd12},
    '{16'h0000, 5'd12},
    '{16'h0555, 5'd12},
    '{16'hF123, 5'd16},
    '{16'h0003, 5'd4}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_clk = 1'b0;
  logic         ser_in = 1'b0;
  logic         load_n = 1'b1;
  logic         clear_n = 1'b1;
  logic [W-1:0] dac_code;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] model_sr = '0;
  logic [W-1:0] last_code = '0;

  always #10 clk = ~clk;

  sdac_input_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
    .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (dac_code !== exp) begin
      n_fail++;
      $display("FAIL %s: dac_code=%h expected=%h", req, dac_code, exp);
    end
  endtask

  // model shifts only when both strobes are high
  task automatic send_bit(input logic b);
    ser_in = b;
    step(SETTLE);
    shift_clk = 1'b1;
    step(SETTLE);
    shift_clk = 1'b0;
    step(SETTLE);
    if (load_n && clear_n) model_sr = {model_sr[W-2:0], b};
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    step(SETTLE);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run exceeded limit");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(SETTLE);
    check("R1 reset code", '0);
    pulse_load();
    check("R1 empty shift register", '0);
    load_n = 1'b1;
    step(SETTLE);

    // table walk: R2 shifting, R9 hold before load, R3 transparent load
    for (int v = 0; v < 6; v++) begin
      last_code = dac_code;
      for (int i = int'(VECS[v].nbits) - 1; i >= 0; i--) send_bit(VECS[v].data[i]);
      check("R9 hold while shifting", last_code);
      pulse_load();
      check("R2 R3 loaded word", model_sr);
      load_n = 1'b1;
      step(SETTLE);
    end

    // R4: clock edges during an open load do not shift
    last_code = dac_code;
    load_n = 1'b0;
    step(SETTLE);
    for (int i = 0; i < 3; i++) send_bit(~model_sr[W-1]);
    check("R4 load low blocks shift", model_sr);
    load_n = 1'b1;
    step(SETTLE);

    // R5: clear forces zero, with load high and with clocking
    clear_n = 1'b0;
    step(SETTLE);
    check("R5 clear with load high", '0);
    // R6: edges while clear low leave shift register intact
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    check("R5 clear with clock edges", '0);
    clear_n = 1'b1;
    step(SETTLE);
    check("R9 zero held after clear", '0);
    pulse_load();
    check("R6 shift register intact", model_sr);
    load_n = 1'b1;
    step(SETTLE);

    // R8: clear released while load still low
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    load_n  = 1'b0;
    clear_n = 1'b0;
    step(SETTLE);
    check("R5 clear with load low", '0);
    clear_n = 1'b1;
    step(SETTLE);
    check("R8 clear rises under load", model_sr);

    // R7: load released while clear still low
    clear_n = 1'b0;
    step(SETTLE);
    load_n = 1'b1;
    step(SETTLE);
    clear_n = 1'b1;
    step(SETTLE);
    check("R7 zero latched", '0);
    send_bit(1'b1);
    check("R9 zero kept while shifting", '0);
    pulse_load();
    check("R2 R3 reload after latch", model_sr);
    load_n = 1'b1;
    step(SETTLE);

    // R2: full-scale word then single-bit shift
    for (int i = 0; i < W; i++) send_bit(1'b1);
    send_bit(1'b0);
    pulse_load();
    check("R2 last W bits kept", {{(W-1){1'b1}}, 1'b0});
    load_n = 1'b1;
    step(SETTLE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule